// File: doc/BRIEF.md
# Expansion Card ROM Paging Trap

This block sits on the bus of an 8-bit home computer expansion card. It watches the CPU address bus and the opcode-fetch, memory, I/O, read, write and reset strobes. When an opcode fetch hits a trapped entry point, it overlays the card's flash ROM on the host ROM region. The trapped entry points are the restart vector for rejected commands and the first fetch after reset. The overlay takes effect on the trapping fetch itself, so that opcode already comes from the card ROM. While the overlay is active, an open-drain drive output holds the host ROM disabled.

The block also decodes a small group of card register ports on all sixteen address bits. The low byte is fixed and the high byte picks the register. One of these ports is a page-out register: any write to it drops the overlay. An opcode fetch from a designated return address drops the overlay too.

A trap-enable input, normally tied to a jumper, suppresses every execution trap and nothing else. Port decoding and page-out keep working, so a card with blank flash can still boot the host and be programmed from it.

Top module: `pageTrap`

## Requirements
- R1: On a clock edge with `rstN` low, the paged state takes the value of `trapEn`. Directly after reset, `paged` equals the `trapEn` level seen during reset.
- R2: An opcode fetch is a cycle with `m1N` and `mreqN` both low. When `trapEn` is high, a fetch from `TRAP_ADDR` (default 0x0008) sets `paged` at the end of that cycle. The card ROM enables and `romHoldDrive` are already active during that same fetch.
- R3: A memory access to `TRAP_ADDR` with `m1N` high never traps. A cycle with `m1N` low and `mreqN` high never traps either.
- R4: With `trapEn` low, no fetch at any address sets `paged`. A reset taken with `trapEn` low leaves `paged` clear.
- R5: `portRd[i]` is high exactly when all of the following hold: `iorqN` is low, `m1N` is high, `rdN` is low, and `addr` equals {`PORT_HI_BASE`+i, 0xFF}. The default ports are 0xF0FF, 0xF1FF, 0xF2FF and 0xF3FF for i = 0..3. `portWr[i]` follows the same rule with `wrN` in place of `rdN`. Every other address gives no strobe.
- R6: A cycle with `iorqN` and `m1N` both low is an interrupt acknowledge and produces no port strobe.
- R7: A write to port index `PAGEOUT_IDX` (default 3, address 0xF3FF) clears `paged` at the end of that cycle.
- R8: An opcode fetch from `RET_ADDR` (default 0x0070) clears `paged` at the end of the cycle. The fetch itself is still served from card ROM.
- R9: `romHoldDrive` is high (the output actively drives) exactly while the overlay is active, meaning `paged` is set or a trapping fetch is in progress. Otherwise it is low (the output floats).
- R10: `cardRomCsN` is low exactly when the overlay is active, `mreqN` is low and `addr[15:14]` is 00. `cardRomOeN` is low exactly when `cardRomCsN` is low and `rdN` is low.
- R11: With `trapEn` low, port strobes and the page-out write behave exactly as in R5 and R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; all state changes on its rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| addr | input | 16 | CPU address bus |
| m1N | input | 1 | Opcode-fetch strobe, active low |
| mreqN | input | 1 | Memory request, active low |
| iorqN | input | 1 | I/O request, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| trapEn | input | 1 | Execution trap enable (jumper), active high |
| portRd | output | 4 | Per-port read strobes, active high |
| portWr | output | 4 | Per-port write strobes, active high |
| cardRomCsN | output | 1 | Card ROM chip select, active low |
| cardRomOeN | output | 1 | Card ROM output enable, active low |
| romHoldDrive | output | 1 | Enable of the open-drain host-ROM hold driver; low means floating |
| paged | output | 1 | Registered overlay state |

## Verification
The assertions assume the bus is never asked to do two things at once. A cycle never has `mreqN` and `iorqN` low together, and `rdN` and `wrN` are never low together. They also assume the return and trap addresses differ, so a single edge cannot both set and clear the overlay. The stimulus drives one bus cycle at a time from an idle state with every strobe high. It changes inputs only on falling clock edges and sweeps addresses with exactly one kind of cycle active. Under those conditions the one-hot port strobe property and the set-and-clear properties keep to their premises.

// File: rtl/pageTrapPkg.sv
package pageTrapPkg;

  // Decoded bus events, datapath -> control
  typedef struct packed {
    logic trapHit;    // opcode fetch at trap vector
    logic retHit;     // opcode fetch at return address
    logic pageOutWr;  // write to page-out port
  } decodeT;

  // Control strobes, control -> datapath
  typedef struct packed {
    logic pageActive; // overlay in effect this cycle
  } strobeT;

endpackage

// File: rtl/pageTrapDecode.sv
module pageTrapDecode
  import pageTrapPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_PORTS = 4,
  parameter int WIN_BITS = 2,
  parameter logic [ADDR_W/2-1:0] PORT_LO = 8'hFF,
  parameter logic [ADDR_W/2-1:0] PORT_HI_BASE = 8'hF0,
  parameter logic [ADDR_W-1:0] TRAP_ADDR = 16'h0008,
  parameter logic [ADDR_W-1:0] RET_ADDR = 16'h0070,
  parameter int PAGEOUT_IDX = 3
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 m1N,
  input  logic                 mreqN,
  input  logic                 iorqN,
  input  logic                 rdN,
  input  logic                 wrN,
  input  strobeT               stb,
  output decodeT               dec,
  output logic [NUM_PORTS-1:0] portRd,
  output logic [NUM_PORTS-1:0] portWr,
  output logic                 cardRomCsN,
  output logic                 cardRomOeN,
  output logic                 romHoldDrive
);
  localparam int HALF_W = ADDR_W / 2;

  logic isFetch;
  logic ioRead;
  logic ioWrite;
  logic inWindow;
  logic [NUM_PORTS-1:0] portMatch;

  // Opcode fetch needs both M1 and MREQ; port access excludes M1 (int ack)
  assign isFetch = !m1N && !mreqN;
  assign ioRead  = !iorqN && m1N && !rdN;
  assign ioWrite = !iorqN && m1N && !wrN;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : gPort
    localparam logic [HALF_W-1:0] HI_BYTE = PORT_HI_BASE + HALF_W'(i);
    assign portMatch[i] = (addr == {HI_BYTE, PORT_LO});
    assign portRd[i] = ioRead && portMatch[i];
    assign portWr[i] = ioWrite && portMatch[i];
  end

  assign dec.trapHit   = isFetch && (addr == TRAP_ADDR);
  assign dec.retHit    = isFetch && (addr == RET_ADDR);
  assign dec.pageOutWr = portWr[PAGEOUT_IDX];

  assign inWindow     = (addr[ADDR_W-1 -: WIN_BITS] == '0);
  assign cardRomCsN   = !(stb.pageActive && !mreqN && inWindow);
  assign cardRomOeN   = cardRomCsN || rdN;
  assign romHoldDrive = stb.pageActive;

endmodule

// File: rtl/pageTrapCtrl.sv
module pageTrapCtrl
  import pageTrapPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   trapEn,
  input  decodeT dec,
  output strobeT stb,
  output logic   paged
);
  logic trapNow;

  assign trapNow = trapEn && dec.trapHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      paged <= trapEn;           // first fetch after reset is trapped
    end else if (dec.pageOutWr || dec.retHit) begin
      paged <= 1'b0;
    end else if (trapNow) begin
      paged <= 1'b1;
    end
  end

  // Overlay already active on the trapping fetch itself
  assign stb.pageActive = paged || trapNow;

endmodule

// File: rtl/pageTrap.sv
module pageTrap
  import pageTrapPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_PORTS = 4,
  parameter int WIN_BITS = 2,
  parameter logic [ADDR_W/2-1:0] PORT_LO = 8'hFF,
  parameter logic [ADDR_W/2-1:0] PORT_HI_BASE = 8'hF0,
  parameter logic [ADDR_W-1:0] TRAP_ADDR = 16'h0008,
  parameter logic [ADDR_W-1:0] RET_ADDR = 16'h0070,
  parameter int PAGEOUT_IDX = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 m1N,
  input  logic                 mreqN,
  input  logic                 iorqN,
  input  logic                 rdN,
  input  logic                 wrN,
  input  logic                 trapEn,
  output logic [NUM_PORTS-1:0] portRd,
  output logic [NUM_PORTS-1:0] portWr,
  output logic                 cardRomCsN,
  output logic                 cardRomOeN,
  output logic                 romHoldDrive,
  output logic                 paged
);
  decodeT dec;
  strobeT stb;

  pageTrapDecode #(
    .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .WIN_BITS(WIN_BITS),
    .PORT_LO(PORT_LO), .PORT_HI_BASE(PORT_HI_BASE),
    .TRAP_ADDR(TRAP_ADDR), .RET_ADDR(RET_ADDR), .PAGEOUT_IDX(PAGEOUT_IDX)
  ) uDecode (
    .addr(addr), .m1N(m1N), .mreqN(mreqN), .iorqN(iorqN),
    .rdN(rdN), .wrN(wrN), .stb(stb), .dec(dec),
    .portRd(portRd), .portWr(portWr),
    .cardRomCsN(cardRomCsN), .cardRomOeN(cardRomOeN),
    .romHoldDrive(romHoldDrive)
  );

  pageTrapCtrl uCtrl (
    .clk(clk), .rstN(rstN), .trapEn(trapEn),
    .dec(dec), .stb(stb), .paged(paged)
  );

endmodule

// File: rtl/pageTrapChecker.sv
module pageTrapChecker #(
  parameter int ADDR_W = 16,
  parameter int NUM_PORTS = 4,
  parameter logic [ADDR_W/2-1:0] PORT_LO = 8'hFF,
  parameter logic [ADDR_W/2-1:0] PORT_HI_BASE = 8'hF0,
  parameter logic [ADDR_W-1:0] TRAP_ADDR = 16'h0008,
  parameter logic [ADDR_W-1:0] RET_ADDR = 16'h0070,
  parameter int PAGEOUT_IDX = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    addr,
  input logic                 m1N,
  input logic                 mreqN,
  input logic                 iorqN,
  input logic                 rdN,
  input logic                 wrN,
  input logic                 trapEn,
  input logic [NUM_PORTS-1:0] portRd,
  input logic [NUM_PORTS-1:0] portWr,
  input logic                 cardRomCsN,
  input logic                 cardRomOeN,
  input logic                 romHoldDrive,
  input logic                 paged
);
  localparam logic [ADDR_W/2-1:0] OUT_HI = PORT_HI_BASE + (ADDR_W/2)'(PAGEOUT_IDX);

  assert_trap_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!m1N && !mreqN && trapEn && addr == TRAP_ADDR) |=> paged);

  assert_no_trap_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!trapEn && !paged) |=> !paged);

  assert_no_data_trap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (m1N && !paged) |=> !paged);

  assert_pageout_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!iorqN && m1N && !wrN && addr == {OUT_HI, PORT_LO}) |=> !paged);

  assert_return_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!m1N && !mreqN && addr == RET_ADDR) |=> !paged);

  assert_int_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!iorqN && !m1N) |-> (portRd == '0 && portWr == '0));

  assert_strobe_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({portRd, portWr}));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    paged |-> romHoldDrive);

  assert_oe_needs_cs_R10: assert property (@(posedge clk) disable iff (!rstN)
    !cardRomOeN |-> (!cardRomCsN && !rdN && !mreqN));

endmodule

bind pageTrap pageTrapChecker #(
  .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .PORT_LO(PORT_LO),
  .PORT_HI_BASE(PORT_HI_BASE), .TRAP_ADDR(TRAP_ADDR),
  .RET_ADDR(RET_ADDR), .PAGEOUT_IDX(PAGEOUT_IDX)
) uChk (
  .clk(clk), .rstN(rstN), .addr(addr), .m1N(m1N), .mreqN(mreqN),
  .iorqN(iorqN), .rdN(rdN), .wrN(wrN), .trapEn(trapEn),
  .portRd(portRd), .portWr(portWr), .cardRomCsN(cardRomCsN),
  .cardRomOeN(cardRomOeN), .romHoldDrive(romHoldDrive), .paged(paged)
);

// File: tb/sim_pageTrap.sv
module sim_pageTrap;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] TRAP = 16'h0008;
  localparam logic [15:0] RET  = 16'h0070;
  localparam logic [15:0] PAGE_OUT_PORT = 16'hF3FF;

  logic clk = 0;
  logic rstN, m1N, mreqN, iorqN, rdN, wrN, trapEn;
  logic [15:0] addr;
  logic [3:0] portRd, portWr;
  logic cardRomCsN, cardRomOeN, romHoldDrive, paged;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic expPaged;

  always #(CLK_PERIOD/2) clk = ~clk;

  pageTrap u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .m1N(m1N), .mreqN(mreqN),
    .iorqN(iorqN), .rdN(rdN), .wrN(wrN), .trapEn(trapEn),
    .portRd(portRd), .portWr(portWr), .cardRomCsN(cardRomCsN),
    .cardRomOeN(cardRomOeN), .romHoldDrive(romHoldDrive), .paged(paged)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%04h actual=%0h expected=%0h", tag, addr, act, exp);
    end
  endtask

  task automatic idle();
    m1N = 1; mreqN = 1; iorqN = 1; rdN = 1; wrN = 1;
  endtask

  // Expected port index from the full 16-bit address (R5)
  function automatic logic [3:0] expPort(input logic [15:0] a);
    if (a[7:0] == 8'hFF && a[15:8] >= 8'hF0 && a[15:8] <= 8'hF3)
      return 4'b0001 << (a[15:8] - 8'hF0);
    return 4'b0000;
  endfunction

  task automatic doReset(input logic en);
    @(negedge clk); idle(); trapEn = en; rstN = 0;
    @(posedge clk); @(negedge clk); rstN = 1;
    expPaged = en;
    #1 chk("R1", paged, expPaged);
  endtask

  task automatic fetch(input logic [15:0] a);
    logic act;
    @(negedge clk); idle(); addr = a; m1N = 0; mreqN = 0; rdN = 0;
    #1;
    act = expPaged || (trapEn && a == TRAP);
    chk("R10", cardRomCsN, !(act && a[15:14] == 2'b00));
    chk("R10", cardRomOeN, !(act && a[15:14] == 2'b00));
    chk("R9", romHoldDrive, act);
    @(posedge clk); #1; idle();
    if (a == RET) expPaged = 0;
    else if (trapEn && a == TRAP) expPaged = 1;
    chk(a == RET ? "R8" : (trapEn ? "R2" : "R4"), paged, expPaged);
  endtask

  task automatic memAccess(input logic [15:0] a, input logic isRead);
    logic act;
    @(negedge clk); idle(); addr = a; mreqN = 0;
    if (isRead) rdN = 0; else wrN = 0;
    #1;
    act = expPaged;
    chk("R10", cardRomCsN, !(act && a[15:14] == 2'b00));
    chk("R10", cardRomOeN, !(act && a[15:14] == 2'b00 && isRead));
    @(posedge clk); #1; idle();
    chk("R3", paged, expPaged);
  endtask

  task automatic ioWrite(input logic [15:0] a, input string tag);
    @(negedge clk); idle(); addr = a; iorqN = 0; wrN = 0;
    #1 chk(tag, portWr, expPort(a));
    chk(tag, portRd, 4'b0000);
    @(posedge clk); #1; idle();
    if (a == PAGE_OUT_PORT) expPaged = 0;
    chk("R7", paged, expPaged);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(); addr = 16'h0000; trapEn = 1; rstN = 0; expPaged = 0;

    // R1: reset with trap enabled pages in; hold active
    doReset(1'b1);
    #1 chk("R9", romHoldDrive, 1'b1);
    // R7: page-out write clears
    ioWrite(PAGE_OUT_PORT, "R7");
    chk("R9", romHoldDrive, 1'b0);

    // R5: exhaustive read sweep over all addresses
    @(negedge clk);
    for (int a = 0; a < 65536; a++) begin
      addr = 16'(a); iorqN = 0; m1N = 1; rdN = 0; wrN = 1; mreqN = 1;
      #1;
      chk("R5", portRd, expPort(16'(a)));
      chk("R5", portWr, 4'b0000);
    end
    idle();

    // R6: interrupt acknowledge on port addresses gives no strobe
    for (int h = 8'hEF; h <= 8'hF4; h++) begin
      @(negedge clk); idle(); addr = {8'(h), 8'hFF}; iorqN = 0; m1N = 0; rdN = 0;
      #1 chk("R6", {portRd, portWr}, 8'h00);
    end

    // R5: write strobes across every high byte with low byte fixed
    for (int h = 0; h < 256; h++) ioWrite({8'(h), 8'hFF}, "R5");
    ioWrite(16'hF0FE, "R5");
    ioWrite(16'hF07F, "R5");

    // R2/R9/R10: fetch sweep over the low ROM, clearing after every trap
    for (int a = 0; a < 512; a++) begin
      fetch(16'(a));
      if (expPaged) ioWrite(PAGE_OUT_PORT, "R7");
    end
    fetch(16'h4008);
    fetch(16'hC008);

    // R3: data read and write at trap vector never trap
    memAccess(TRAP, 1'b1);
    memAccess(TRAP, 1'b0);
    // R3: M1 low without MREQ (no memory request) never traps
    @(negedge clk); idle(); addr = TRAP; m1N = 0; iorqN = 1;
    @(posedge clk); #1; idle();
    chk("R3", paged, 1'b0);

    // R10: ROM window with overlay active
    fetch(TRAP);
    memAccess(16'h0000, 1'b1);
    memAccess(16'h3FFF, 1'b1);
    memAccess(16'h3FFF, 1'b0);
    memAccess(16'h4000, 1'b1);
    memAccess(16'hFFFF, 1'b1);
    // R8: return fetch served from card, then overlay drops
    fetch(RET);
    memAccess(16'h0100, 1'b1);

    // R4/R11: trap disabled
    doReset(1'b0);
    fetch(TRAP);
    fetch(16'h0000);
    chk("R4", romHoldDrive, 1'b0);
    for (int h = 8'hEE; h <= 8'hF5; h++) ioWrite({8'(h), 8'hFF}, "R11");
    @(negedge clk); idle(); addr = 16'hF2FF; iorqN = 0; rdN = 0;
    #1 chk("R11", portRd, 4'b0100);
    idle();
    // R11: page-out still clears a trapped state after trapEn drops
    trapEn = 1;
    fetch(TRAP);
    @(negedge clk); trapEn = 0;
    ioWrite(PAGE_OUT_PORT, "R11");
    chk("R11", paged, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule